// File: doc/BRIEF.md
# Event-Driven Multimode Timer/Counter

This block is a 16-bit timer/counter with four count modes: up, down, up/down and event counting. In up mode it counts to a programmable period and wraps. In down mode it reloads from the period. In up/down mode it turns around at both endpoints, which gives center-aligned waveforms. The counter runs on every clock as a timer, or only on events from a hardware count pin.

Five hardware pins (count, capture, reload, start, stop) each pass through a two-flop synchronizer and a per-pin edge selector. The selector turns the pin into internal events on a rising edge, a falling edge, either edge, or on every cycle the pin is high. The block compares the counter with period and compare values. It drives three one-cycle event pulses (overflow, underflow, compare hit) and a PWM level.

A capture event stores the counter in a one-entry holding register. A sticky overrun flag marks any capture that lands on an unread value. All configuration goes through a plain register port. There is no data stream at the edge, so no valid/ready handshake is used and nothing can apply back-pressure.

Top module: `tmr_evt_unit`

## Requirements
- R1: After reset the counter is 0, all event outputs and `pwm_o` are low, run is off, period reads 0xFFFF, and compare, capture and status read 0.
- R2: Up mode (mode field 00). A tick with counter >= period loads 0 and pulses `ovf_o`; any other tick adds 1. The pulse is high in the cycle the counter shows the new value.
- R3: Down mode (mode field 01). A tick with counter 0 loads the period and pulses `unf_o`; any other tick subtracts 1. `ovf_o` and `unf_o` are never high together.
- R4: Up/down mode (mode field 10). Counting up, a tick at counter >= period pulses `ovf_o` and turns toward 0. Counting down, a tick at 0 pulses `unf_o` and turns upward. With a nonzero period, no tick leaves the counter unchanged. Any counter load restarts the direction as up.
- R5: Each pin's 2-bit selector works as follows: 00 rising edge, 01 falling edge, 10 either edge, 11 one event per cycle the pin is high. The selector bits sit in the edge register at count [1:0], capture [3:2], reload [5:4], start [7:6] and stop [9:8]. The first event acts on the third clock edge after the pin changes.
- R6: `cmp_o` pulses for one cycle when a tick moves the counter to a value equal to compare.
- R7: `pwm_o` is high exactly while counter < compare. A compare of 0 gives a constant low; a compare above the period gives a constant high.
- R8: A capture event copies the counter (its value before that clock edge) into the capture register and sets the full flag. A capture while full sets the sticky overrun flag. A read of the capture register with `rd_en_i` clears full. A write to the status address clears overrun.
- R9: A start event sets run, and a stop event clears it; stop wins over start. A reload event loads the period in down mode and 0 otherwise. A register write wins over both.
- R10: Control bit 3 selects the tick source: 0 ticks on every clock while run is set, 1 ticks only on count-pin events while run is set. Without a tick or a load, the counter holds.
- R11: Register map (address: use): 0 control {bit3 source, bits2:1 mode, bit0 run}, 1 edge selectors, 2 period, 3 compare, 4 counter (write loads it), 5 capture (read only), 6 status {bit1 full, bit0 overrun}. `rdata_o` is combinational from `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Read strobe (consumes capture) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| cnt_in_i | input | 1 | Hardware count pin |
| cap_in_i | input | 1 | Hardware capture pin |
| rld_in_i | input | 1 | Hardware reload pin |
| start_in_i | input | 1 | Hardware start pin |
| stop_in_i | input | 1 | Hardware stop pin |
| cnt_o | output | 16 | Current counter value |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |
| cmp_o | output | 1 | Compare hit pulse |
| pwm_o | output | 1 | PWM level |

## Verification
On every cycle, the assertions check the counter arithmetic:
- the up-mode wrap and the down-mode reload, together with their pulses;
- that up/down never stalls on a nonzero period;
- that the counter holds when there is no tick or load;
- that a compare hit shows the compare value;
- that a zero compare keeps PWM low;
- that overflow and underflow are never high together.

Only the bench scenarios can show the rest:
- the edge-selector encodings and the synchronizer latency;
- capture timing, overrun stickiness and clearing;
- start/stop/reload priority;
- register readback;
- the full step-by-step waveforms of each mode against an independent model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CM_UP  = 2'b00,
    CM_DN  = 2'b01,
    CM_UD  = 2'b10,
    CM_RSV = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ES_RISE  = 2'b00,
    ES_FALL  = 2'b01,
    ES_BOTH  = 2'b10,
    ES_LEVEL = 2'b11
  } edge_sel_e;

  localparam int unsigned HW_PINS  = 5;
  localparam int unsigned PIN_CNT  = 0;
  localparam int unsigned PIN_CAP  = 1;
  localparam int unsigned PIN_RLD  = 2;
  localparam int unsigned PIN_STRT = 3;
  localparam int unsigned PIN_STOP = 4;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_EDGE = 3'd1;
  localparam logic [2:0] A_PER  = 3'd2;
  localparam logic [2:0] A_CMP  = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;
  localparam logic [2:0] A_CAP  = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int unsigned N = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   pin_i,
  input  logic [2*N-1:0] sel_i,
  output logic [N-1:0]   evt_o
);
  import tmr_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic s1_q, s2_q, pv_q;
    edge_sel_e sel;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        pv_q <= 1'b0;
      end else begin
        s1_q <= pin_i[i];
        s2_q <= s1_q;
        pv_q <= s2_q;
      end
    end

    assign sel = edge_sel_e'(sel_i[2*i +: 2]);

    always_comb begin
      unique case (sel)
        ES_RISE: evt_o[i] = s2_q & ~pv_q;
        ES_FALL: evt_o[i] = ~s2_q & pv_q;
        ES_BOTH: evt_o[i] = s2_q ^ pv_q;
        default: evt_o[i] = s2_q;
      endcase
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int unsigned W  = 16,
  parameter int unsigned NP = 5,
  localparam int unsigned EW = 2 * NP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [2:0]           addr_i,
  input  logic [W-1:0]         wdata_i,
  output logic [W-1:0]         rdata_o,
  input  logic                 start_evt_i,
  input  logic                 stop_evt_i,
  input  logic                 cap_evt_i,
  input  logic [W-1:0]         cnt_i,
  output logic                 run_o,
  output tmr_pkg::cnt_mode_e   mode_o,
  output logic                 src_evt_o,
  output logic [EW-1:0]        edge_cfg_o,
  output logic [W-1:0]         per_o,
  output logic [W-1:0]         cmp_o,
  output logic                 cnt_wr_o,
  output logic [W-1:0]         cnt_wr_val_o
);
  import tmr_pkg::*;

  logic          run_q, src_q, full_q, ovr_q;
  cnt_mode_e     mode_q;
  logic [EW-1:0] edge_q;
  logic [W-1:0]  per_q, cmp_q, cap_q;
  logic          wr_ctrl, wr_stat, cap_rd;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign cap_rd  = rd_en_i && (addr_i == A_CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      src_q  <= 1'b0;
      mode_q <= CM_UP;
      edge_q <= '0;
      per_q  <= '1;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wdata_i[0];
        mode_q <= cnt_mode_e'(wdata_i[2:1]);
        src_q  <= wdata_i[3];
      end else if (stop_evt_i) begin
        run_q <= 1'b0;
      end else if (start_evt_i) begin
        run_q <= 1'b1;
      end
      if (wr_en_i && addr_i == A_EDGE) edge_q <= wdata_i[EW-1:0];
      if (wr_en_i && addr_i == A_PER)  per_q  <= wdata_i;
      if (wr_en_i && addr_i == A_CMP)  cmp_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (cap_evt_i) begin
        cap_q  <= cnt_i;
        full_q <= 1'b1;
        if (full_q && !cap_rd) ovr_q <= 1'b1;
        else if (wr_stat)      ovr_q <= 1'b0;
      end else begin
        if (cap_rd)  full_q <= 1'b0;
        if (wr_stat) ovr_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[3:0]    = {src_q, mode_q, run_q};
      A_EDGE: rdata_o[EW-1:0] = edge_q;
      A_PER:  rdata_o         = per_q;
      A_CMP:  rdata_o         = cmp_q;
      A_CNT:  rdata_o         = cnt_i;
      A_CAP:  rdata_o         = cap_q;
      A_STAT: rdata_o[1:0]    = {full_q, ovr_q};
      default: rdata_o        = '0;
    endcase
  end

  assign run_o        = run_q;
  assign mode_o       = mode_q;
  assign src_evt_o    = src_q;
  assign edge_cfg_o   = edge_q;
  assign per_o        = per_q;
  assign cmp_o        = cmp_q;
  assign cnt_wr_o     = wr_en_i && (addr_i == A_CNT);
  assign cnt_wr_val_o = wdata_i;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  tmr_pkg::cnt_mode_e mode_i,
  input  logic [W-1:0]       per_i,
  input  logic [W-1:0]       cmp_i,
  input  logic               ld_i,
  input  logic [W-1:0]       ld_val_i,
  output logic [W-1:0]       cnt_o,
  output logic               ovf_o,
  output logic               unf_o,
  output logic               hit_o,
  output logic               pwm_o
);
  import tmr_pkg::*;

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         ovf_q, unf_q, hit_q;
  logic         ovf_d, unf_d;
  logic [W-1:0] one_or_zero;

  assign one_or_zero = (per_i == '0) ? '0 : W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    if (ld_i) begin
      cnt_d  = ld_val_i;
      down_d = 1'b0;
    end else if (tick_i) begin
      unique case (mode_i)
        CM_DN: begin
          if (cnt_q == '0) begin
            cnt_d = per_i;
            unf_d = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        CM_UD: begin
          if (!down_q) begin
            if (cnt_q >= per_i) begin
              ovf_d  = 1'b1;
              down_d = 1'b1;
              cnt_d  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              unf_d  = 1'b1;
              down_d = 1'b0;
              cnt_d  = one_or_zero;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: begin
          if (cnt_q >= per_i) begin
            cnt_d = '0;
            ovf_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      hit_q  <= tick_i && !ld_i && (cnt_d == cmp_i);
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
  assign hit_o = hit_q;
  assign pwm_o = cnt_q < cmp_i;
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         cnt_in_i,
  input  logic         cap_in_i,
  input  logic         rld_in_i,
  input  logic         start_in_i,
  input  logic         stop_in_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         unf_o,
  output logic         cmp_o,
  output logic         pwm_o
);
  import tmr_pkg::*;

  localparam int unsigned NP = HW_PINS;

  logic [NP-1:0]   pins, evt;
  logic [2*NP-1:0] edge_cfg;
  logic            run, src_evt, cnt_wr, tick, cnt_ld;
  cnt_mode_e       mode;
  logic [W-1:0]    period, compare, cnt_wr_val, ld_val;

  assign pins = {stop_in_i, start_in_i, rld_in_i, cap_in_i, cnt_in_i};

  tmr_edge_det #(.N(NP)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .sel_i  (edge_cfg),
    .evt_o  (evt)
  );

  tmr_regs #(.W(W), .NP(NP)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .start_evt_i  (evt[PIN_STRT]),
    .stop_evt_i   (evt[PIN_STOP]),
    .cap_evt_i    (evt[PIN_CAP]),
    .cnt_i        (cnt_o),
    .run_o        (run),
    .mode_o       (mode),
    .src_evt_o    (src_evt),
    .edge_cfg_o   (edge_cfg),
    .per_o        (period),
    .cmp_o        (compare),
    .cnt_wr_o     (cnt_wr),
    .cnt_wr_val_o (cnt_wr_val)
  );

  assign tick   = run && (src_evt ? evt[PIN_CNT] : 1'b1);
  assign cnt_ld = cnt_wr || evt[PIN_RLD];
  assign ld_val = cnt_wr ? cnt_wr_val : ((mode == CM_DN) ? period : '0);

  tmr_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .mode_i   (mode),
    .per_i    (period),
    .cmp_i    (compare),
    .ld_i     (cnt_ld),
    .ld_val_i (ld_val),
    .cnt_o    (cnt_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o),
    .hit_o    (cmp_o),
    .pwm_o    (pwm_o)
  );
endmodule

// File: rtl/tmr_evt_unit_chk.sv
module tmr_evt_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               ld,
  input tmr_pkg::cnt_mode_e mode,
  input logic [W-1:0]       per,
  input logic [W-1:0]       cmp,
  input logic [W-1:0]       cnt,
  input logic               ovf,
  input logic               unf,
  input logic               hit,
  input logic               pwm
);
  import tmr_pkg::*;

  a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UP && tick && !ld && cnt >= per) |=> (cnt == '0 && ovf));

  a_r3_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_DN && tick && !ld && cnt == '0) |=> (cnt == $past(per) && unf));

  a_r3_no_dual_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  a_r4_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UD && tick && !ld && per != '0) |=> (cnt != $past(cnt)));

  a_r6_hit_value: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (cnt == $past(cmp)));

  a_r7_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |-> !pwm);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));
endmodule

bind tmr_evt_unit tmr_evt_unit_chk #(.W(W)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .tick  (tick),
  .ld    (cnt_ld),
  .mode  (mode),
  .per   (period),
  .cmp   (compare),
  .cnt   (cnt_o),
  .ovf   (ovf_o),
  .unf   (unf_o),
  .hit   (cmp_o),
  .pwm   (pwm_o)
);

// File: tb/tmr_evt_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_evt_unit_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         p_cnt = 0, p_cap = 0, p_rld = 0, p_start = 0, p_stop = 0;
  logic [W-1:0] cnt;
  logic         ovf, unf, hit, pwm;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tmr_evt_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cnt_in_i(p_cnt), .cap_in_i(p_cap), .rld_in_i(p_rld),
    .start_in_i(p_start), .stop_in_i(p_stop),
    .cnt_o(cnt), .ovf_o(ovf), .unf_o(unf), .cmp_o(hit), .pwm_o(pwm)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input bit consume, output int v);
    @(negedge clk);
    addr = a; rd_en = consume;
    #1 v = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Checks mode behaviour cycle by cycle against a bench model.
  task automatic run_model(input int md, input int P, input int C, input int n, input string tag);
    int prev, dir, e;
    bit eo, eu;
    prev = int'(cnt); dir = 0;
    for (int k = 0; k < n; k++) begin
      eo = 0; eu = 0;
      @(negedge clk);
      case (md)
        1: if (prev == 0) begin e = P; eu = 1; end else e = prev - 1;
        2: begin
          if (dir == 0) begin
            if (prev >= P) begin e = prev - 1; eo = 1; dir = 1; end else e = prev + 1;
          end else begin
            if (prev == 0) begin e = 1; eu = 1; dir = 0; end else e = prev - 1;
          end
        end
        default: if (prev >= P) begin e = 0; eo = 1; end else e = prev + 1;
      endcase
      chk({tag, " count"}, int'(cnt), e);
      chk({tag, " ovf"}, int'(ovf), int'(eo));
      chk({tag, " unf"}, int'(unf), int'(eu));
      chk("R6 compare hit", int'(hit), int'(e == C));
      chk("R7 pwm level", int'(pwm), int'(e < C));
      prev = e;
    end
  endtask

  task automatic setup(input int P, input int C, input int ctrl);
    wr(3'd2, P);
    wr(3'd3, C);
    wr(3'd4, 0);
    wr(3'd0, ctrl);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 count", int'(cnt), 0);
    chk("R1 events", int'({ovf, unf, hit, pwm}), 0);
    rd(3'd0, 0, v); chk("R1 ctrl", v, 0);
    rd(3'd2, 0, v); chk("R1 period", v, 16'hFFFF);
    rd(3'd3, 0, v); chk("R1 compare", v, 0);
    rd(3'd5, 0, v); chk("R1 capture", v, 0);
    rd(3'd6, 0, v); chk("R1 status", v, 0);
    wr(3'd1, 16'h02AA);
    rd(3'd1, 0, v); chk("R11 edge readback", v, 16'h02AA);
    wr(3'd1, 0);
  endtask

  task automatic t_up();
    setup(4, 2, 16'h1);
    run_model(0, 4, 2, 14, "R2 up");
    wr(3'd0, 0);
  endtask

  task automatic t_down();
    setup(3, 2, 16'h3);
    run_model(1, 3, 2, 12, "R3 down");
    wr(3'd0, 0);
  endtask

  task automatic t_updown();
    setup(3, 1, 16'h5);
    run_model(2, 3, 1, 16, "R4 updown");
    wr(3'd0, 0);
  endtask

  task automatic t_pwm_limits();
    setup(5, 0, 16'h1);
    run_model(0, 5, 0, 8, "R7 cmp0");
    wr(3'd0, 0);
    setup(5, 6, 16'h1);
    run_model(0, 5, 6, 8, "R7 cmp>per");
    wr(3'd0, 0);
  endtask

  task automatic pulse_cnt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); p_cnt = 1'b1;
      idle(3);
      p_cnt = 1'b0;
      idle(3);
    end
    idle(4);
  endtask

  task automatic t_count_edges();
    int v;
    wr(3'd1, 0);             // count pin rising
    setup(16'hFFFF, 16'hFFFF, 16'h9);
    pulse_cnt(3);
    chk("R5 rising edges", int'(cnt), 3);
    wr(3'd4, 0); wr(3'd1, 1); // falling
    pulse_cnt(3);
    chk("R5 falling edges", int'(cnt), 3);
    wr(3'd4, 0); wr(3'd1, 2); // both
    pulse_cnt(3);
    chk("R5 both edges", int'(cnt), 6);
    wr(3'd4, 0); wr(3'd1, 3); // level
    @(negedge clk); p_cnt = 1'b1;
    idle(5);
    p_cnt = 1'b0;
    idle(5);
    chk("R5 pass-through level", int'(cnt), 5);
    v = int'(cnt);
    idle(4);
    chk("R10 no tick holds", int'(cnt), v);
    wr(3'd0, 0); wr(3'd1, 0);
  endtask

  task automatic t_capture();
    int v, exp_cap;
    setup(16'hFFFF, 16'hFFFF, 16'h1);
    idle(3);
    @(negedge clk); p_cap = 1'b1;
    @(negedge clk); p_cap = 1'b0;
    @(negedge clk); exp_cap = int'(cnt);
    idle(2);
    rd(3'd6, 0, v); chk("R8 full set", v, 2);
    rd(3'd5, 1, v); chk("R8 capture value", v, exp_cap);
    rd(3'd6, 0, v); chk("R8 full cleared by read", v, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); p_cap = 1'b1;
      idle(2); p_cap = 1'b0;
      idle(2);
    end
    rd(3'd6, 0, v); chk("R8 overrun set", v, 3);
    wr(3'd6, 0);
    rd(3'd6, 0, v); chk("R8 overrun cleared", v, 2);
    wr(3'd0, 0);
  endtask

  task automatic pulse_pin(input int which);
    @(negedge clk);
    case (which)
      0: p_start = 1'b1;
      1: p_stop = 1'b1;
      default: p_rld = 1'b1;
    endcase
    idle(2);
    p_start = 1'b0; p_stop = 1'b0; p_rld = 1'b0;
    idle(3);
  endtask

  task automatic t_start_stop();
    int a, v;
    wr(3'd2, 7);
    wr(3'd4, 5);
    wr(3'd0, 0);
    a = int'(cnt); idle(2);
    chk("R10 stopped holds", int'(cnt), a);
    pulse_pin(0);
    a = int'(cnt); @(negedge clk);
    chk("R9 start runs", int'(cnt), (a >= 7) ? 0 : a + 1);
    pulse_pin(1);
    rd(3'd0, 0, v); chk("R9 stop clears run", v & 1, 0);
    a = int'(cnt); idle(3);
    chk("R9 stopped count holds", int'(cnt), a);
    wr(3'd4, 4);
    pulse_pin(2);
    chk("R9 reload up to 0", int'(cnt), 0);
    wr(3'd0, 16'h2);
    pulse_pin(2);
    chk("R9 reload down to period", int'(cnt), 7);
    wr(3'd0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_up();
    t_down();
    t_updown();
    t_pwm_limits();
    t_count_edges();
    t_capture();
    t_start_stop();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule